// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block holds the in-flight instructions of an out-of-order pipeline in program order and decides, each cycle, which of them leave. Rename hands it a group of up to `RN_W` instructions, each carrying a sequence number and a few attribute bits. Execute reports finished instructions by sequence number, up to `EX_W` per cycle. The block retires up to `CM_W` ready entries from the head each cycle. It drives a registered feedback bundle back to execute: the latest done sequence number, a load-retired flag, a request to run a held store or non-speculative instruction, and the squash flags.

When execute signals a mispredict, the controller leaves normal operation and walks the buffer backwards from the tail. It discards one younger entry per cycle until the tail holds the instruction that caused the squash, or an older one. Entries that execute has marked as killed are not walked out. They stay in place and leave silently when they reach the head.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset the buffer is empty: `fb_free` equals `ENTRIES`, and every feedback flag (`fb_done_vld`, `fb_squash`, `fb_walk`, `fb_ns_vld`, `fb_ld_cmt`) is 0.
- R2: While running, each rename lane with `rn_vld`=1 and `rn_kil`=0 is written at the tail, with lanes taken in ascending lane order. Lanes with `rn_kil`=1 are dropped and use no space. `fb_free` falls by the number written, after that clock edge.
- R3: `rn_stall` is 1, and no lane is written, when the number of lanes that need space exceeds the free entries at the start of the cycle. It is also 1 while walking and in the cycle a squash request is accepted. Lanes with `rn_kil`=1 never cause a stall.
- R4: In one cycle, retirement removes at most `CM_W` entries, oldest first, taken only from entries present at the start of that cycle. It stops at the first entry that is not ready. A normal retirement sets `fb_done_vld` and puts the youngest retired sequence number on `fb_done_seq`.
- R5: `fb_ld_cmt` is 1 exactly when an entry inserted with `rn_ld`=1 retires normally in that cycle.
- R6: A ready head marked killed is removed without raising `fb_done_vld`, if it has executed. If it has not executed, retirement stops for the cycle and nothing is removed.
- R7: A ready head that is neither killed nor executed, and was inserted with `rn_nsp`=1, raises `fb_ns_vld` with its sequence number on `fb_ns_seq`. The head's ready flag is then cleared and retirement stops, so the request is not repeated on the next cycle.
- R8: An execute lane with `ex_vld`=1 sets ready on the occupied entry whose sequence number matches. It also ORs `ex_exe` into the executed flag and `ex_kil` into the killed flag. These marks apply after that cycle's retirement, so they take effect one cycle later.
- R9: When running, `sq_req`=1 is accepted. After that edge `fb_squash`=1, `fb_walk`=1, `fb_done_vld`=1 and `fb_done_seq`=`sq_seq`, and `fb_mis`, `fb_tkn`, `fb_npc` and `fb_mpc` copy the request fields. Nothing is inserted or retired in that cycle.
- R10: Each walk cycle removes the tail entry while its sequence number is newer than the squash number (compared modulo 2^`SEQ_W`). Each removal raises `fb_walk` and reports the removed number on `fb_done_seq`. When the tail is no longer newer, the controller returns to running with `fb_walk`=0.
- R11: A squash request that arrives during a walk is ignored.
- R12: `fb_free` always shows `ENTRIES` minus the current occupancy and never exceeds `ENTRIES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_vld | input | RN_W | Rename lane valid |
| rn_seq | input | RN_W*SEQ_W | Rename lane sequence numbers, lane l at bits l*SEQ_W |
| rn_kil | input | RN_W | Lane already killed, drop it |
| rn_rdy | input | RN_W | Entry ready at insertion |
| rn_nsp | input | RN_W | Store or non-speculative instruction |
| rn_ld | input | RN_W | Load instruction |
| rn_stall | output | 1 | Rename group not accepted this cycle |
| ex_vld | input | EX_W | Execute completion lane valid |
| ex_seq | input | EX_W*SEQ_W | Completed sequence numbers |
| ex_exe | input | EX_W | Instruction has executed |
| ex_kil | input | EX_W | Instruction has been killed |
| sq_req | input | 1 | Squash request from execute |
| sq_seq | input | SEQ_W | Sequence number of the squashing instruction |
| sq_mis | input | 1 | Squash is a branch mispredict |
| sq_tkn | input | 1 | Branch outcome taken |
| sq_npc | input | PC_W | Corrected next PC |
| sq_mpc | input | PC_W | PC of the mispredicted branch |
| fb_done_vld | output | 1 | fb_done_seq carries a new value |
| fb_done_seq | output | SEQ_W | Done sequence number |
| fb_squash | output | 1 | Squash accepted this cycle |
| fb_walk | output | 1 | Squash in progress |
| fb_mis | output | 1 | Forwarded mispredict flag |
| fb_tkn | output | 1 | Forwarded taken flag |
| fb_npc | output | PC_W | Forwarded next PC |
| fb_mpc | output | PC_W | Forwarded mispredicted PC |
| fb_ns_vld | output | 1 | Request to execute a held head |
| fb_ns_seq | output | SEQ_W | Sequence number of the held head |
| fb_ld_cmt | output | 1 | A load retired |
| fb_free | output | $clog2(ENTRIES+1) | Free entry count |

## Verification
`rn_stall` depends on the current inputs, so the bench checks it after the inputs settle and before the clock edge. Every other feedback output is registered. The bench reads each one just after the edge that consumed the stimulus, so a retirement, a squash acceptance, a walk step or an insertion is checked on the first edge. An execute completion changes only ready state. Its retirement therefore appears one edge later, and the bench checks that the completing edge itself shows nothing. A held head raises its request on the edge after its insertion, and the bench checks that the following edge shows no repeat.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WALK = 1'b1
  } rob_st_e;

  // per-entry status bits
  typedef struct packed {
    logic rdy;   // may be considered for retirement
    logic exe;   // has executed
    logic kil;   // killed, retire silently
    logic nsp;   // store / non-speculative
    logic ld;    // load
  } rob_flg_t;

endpackage

// File: rtl/rob_insert_map.sv
module rob_insert_map #(
  parameter int RN_W = 2,
  parameter int NW   = 2
) (
  input  logic [RN_W-1:0]    vld,
  input  logic [RN_W-1:0]    kil,
  output logic [RN_W-1:0]    take,
  output logic [RN_W*NW-1:0] ofs,
  output logic [NW-1:0]      tot
);
  // compact surviving lanes onto consecutive slots
  always_comb begin
    logic [NW-1:0] acc;
    acc = '0;
    for (int l = 0; l < RN_W; l++) begin
      take[l]           = vld[l] & ~kil[l];
      ofs[l*NW +: NW]   = acc;
      acc               = acc + NW'(take[l]);
    end
    tot = acc;
  end
endmodule

// File: rtl/rob_mark_match.sv
module rob_mark_match #(
  parameter int ENTRIES = 8,
  parameter int EX_W    = 2,
  parameter int SEQ_W   = 8
) (
  input  logic [SEQ_W-1:0]      seq_q [ENTRIES],
  input  logic [ENTRIES-1:0]    occ,
  input  logic [EX_W-1:0]       ex_vld,
  input  logic [EX_W*SEQ_W-1:0] ex_seq,
  input  logic [EX_W-1:0]       ex_exe,
  input  logic [EX_W-1:0]       ex_kil,
  output logic [ENTRIES-1:0]    hit,
  output logic [ENTRIES-1:0]    set_exe,
  output logic [ENTRIES-1:0]    set_kil
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_comb begin
      hit[i]     = 1'b0;
      set_exe[i] = 1'b0;
      set_kil[i] = 1'b0;
      for (int l = 0; l < EX_W; l++) begin
        if (occ[i] && ex_vld[l] && (ex_seq[l*SEQ_W +: SEQ_W] == seq_q[i])) begin
          hit[i]     = 1'b1;
          set_exe[i] = set_exe[i] | ex_exe[l];
          set_kil[i] = set_kil[i] | ex_kil[l];
        end
      end
    end
  end
endmodule

// File: rtl/rob_retire_scan.sv
module rob_retire_scan
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CM_W    = 2,
  parameter int SEQ_W   = 8
) (
  input  logic [$clog2(ENTRIES)-1:0]   head,
  input  logic [$clog2(ENTRIES+1)-1:0] cnt,
  input  rob_flg_t                     flg_q [ENTRIES],
  input  logic [SEQ_W-1:0]             seq_q [ENTRIES],
  output logic [$clog2(ENTRIES+1)-1:0] pop,
  output logic                         done_vld,
  output logic [SEQ_W-1:0]             done_seq,
  output logic                         ld_cmt,
  output logic                         ns_vld,
  output logic [SEQ_W-1:0]             ns_seq,
  output logic [$clog2(ENTRIES)-1:0]   ns_idx
);
  localparam int PW = $clog2(ENTRIES);
  localparam int CW = $clog2(ENTRIES+1);

  always_comb begin
    logic          go;
    logic [PW-1:0] idx;
    go       = 1'b1;
    pop      = '0;
    done_vld = 1'b0;
    done_seq = '0;
    ld_cmt   = 1'b0;
    ns_vld   = 1'b0;
    ns_seq   = '0;
    ns_idx   = '0;
    for (int k = 0; k < CM_W; k++) begin
      idx = PW'((int'(head) + k) % ENTRIES);
      if (go && (k < int'(cnt)) && flg_q[idx].rdy) begin
        if (flg_q[idx].kil) begin
          if (flg_q[idx].exe) pop = pop + CW'(1);
          else                go  = 1'b0;
        end else if (!flg_q[idx].exe) begin
          if (flg_q[idx].nsp) begin
            ns_vld = 1'b1;
            ns_seq = seq_q[idx];
            ns_idx = idx;
          end
          go = 1'b0;
        end else begin
          pop      = pop + CW'(1);
          done_vld = 1'b1;
          done_seq = seq_q[idx];
          ld_cmt   = ld_cmt | flg_q[idx].ld;
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int RN_W    = 2,
  parameter int EX_W    = 2,
  parameter int CM_W    = 2,
  parameter int SEQ_W   = 8,
  parameter int PC_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RN_W-1:0]              rn_vld,
  input  logic [RN_W*SEQ_W-1:0]        rn_seq,
  input  logic [RN_W-1:0]              rn_kil,
  input  logic [RN_W-1:0]              rn_rdy,
  input  logic [RN_W-1:0]              rn_nsp,
  input  logic [RN_W-1:0]              rn_ld,
  output logic                         rn_stall,
  input  logic [EX_W-1:0]              ex_vld,
  input  logic [EX_W*SEQ_W-1:0]        ex_seq,
  input  logic [EX_W-1:0]              ex_exe,
  input  logic [EX_W-1:0]              ex_kil,
  input  logic                         sq_req,
  input  logic [SEQ_W-1:0]             sq_seq,
  input  logic                         sq_mis,
  input  logic                         sq_tkn,
  input  logic [PC_W-1:0]              sq_npc,
  input  logic [PC_W-1:0]              sq_mpc,
  output logic                         fb_done_vld,
  output logic [SEQ_W-1:0]             fb_done_seq,
  output logic                         fb_squash,
  output logic                         fb_walk,
  output logic                         fb_mis,
  output logic                         fb_tkn,
  output logic [PC_W-1:0]              fb_npc,
  output logic [PC_W-1:0]              fb_mpc,
  output logic                         fb_ns_vld,
  output logic [SEQ_W-1:0]             fb_ns_seq,
  output logic                         fb_ld_cmt,
  output logic [$clog2(ENTRIES+1)-1:0] fb_free
);
  localparam int PW = $clog2(ENTRIES);
  localparam int CW = $clog2(ENTRIES+1);
  localparam int NW = $clog2(RN_W+1);

  function automatic logic [PW-1:0] wrap_ptr(input int v);
    return PW'(v % ENTRIES);
  endfunction

  function automatic logic seq_newer(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  // state
  rob_st_e          st_q, st_d;
  logic [PW-1:0]    head_q, head_d, tail_q, tail_d, tail_m1;
  logic [CW-1:0]    cnt_q, cnt_d, free;
  logic [SEQ_W-1:0] sqs_q, sqs_d;
  rob_flg_t         flg_q [ENTRIES];
  rob_flg_t         flg_d [ENTRIES];
  logic [SEQ_W-1:0] seq_q [ENTRIES];
  logic [SEQ_W-1:0] seq_wd [ENTRIES];
  logic [ENTRIES-1:0] seq_we, occ;

  // feedback next values
  logic             done_vld_d, squash_d, walk_d, mis_d, tkn_d, ns_vld_d, ld_cmt_d;
  logic [SEQ_W-1:0] done_seq_d, ns_seq_d;
  logic [PC_W-1:0]  npc_d, mpc_d;

  // sub-block wires
  logic [RN_W-1:0]    take;
  logic [RN_W*NW-1:0] ofs;
  logic [NW-1:0]      tot;
  logic [ENTRIES-1:0] hit, set_exe, set_kil;
  logic [CW-1:0]      pop;
  logic               sc_done_vld, sc_ld, sc_ns_vld;
  logic [SEQ_W-1:0]   sc_done_seq, sc_ns_seq;
  logic [PW-1:0]      sc_ns_idx;

  assign free    = CW'(ENTRIES) - cnt_q;
  assign fb_free = free;
  assign tail_m1 = wrap_ptr(int'(tail_q) + ENTRIES - 1);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      occ[i] = int'(wrap_ptr(i - int'(head_q) + ENTRIES)) < int'(cnt_q);
  end

  assign rn_stall = (st_q != ST_RUN) | sq_req | (int'(tot) > int'(free));

  rob_insert_map #(.RN_W(RN_W), .NW(NW)) u_map (
    .vld(rn_vld), .kil(rn_kil), .take(take), .ofs(ofs), .tot(tot)
  );

  rob_mark_match #(.ENTRIES(ENTRIES), .EX_W(EX_W), .SEQ_W(SEQ_W)) u_mark (
    .seq_q(seq_q), .occ(occ), .ex_vld(ex_vld), .ex_seq(ex_seq),
    .ex_exe(ex_exe), .ex_kil(ex_kil), .hit(hit), .set_exe(set_exe), .set_kil(set_kil)
  );

  rob_retire_scan #(.ENTRIES(ENTRIES), .CM_W(CM_W), .SEQ_W(SEQ_W)) u_scan (
    .head(head_q), .cnt(cnt_q), .flg_q(flg_q), .seq_q(seq_q), .pop(pop),
    .done_vld(sc_done_vld), .done_seq(sc_done_seq), .ld_cmt(sc_ld),
    .ns_vld(sc_ns_vld), .ns_seq(sc_ns_seq), .ns_idx(sc_ns_idx)
  );

  // next-state
  always_comb begin
    logic [PW-1:0] slot;
    logic [NW-1:0] n_ins;
    st_d   = st_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    sqs_d  = sqs_q;
    slot   = '0;
    n_ins  = '0;
    seq_we = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      flg_d[i]  = flg_q[i];
      seq_wd[i] = seq_q[i];
    end
    done_vld_d = 1'b0;  done_seq_d = '0;
    squash_d   = 1'b0;  walk_d     = 1'b0;
    mis_d      = 1'b0;  tkn_d      = 1'b0;
    npc_d      = '0;    mpc_d      = '0;
    ns_vld_d   = 1'b0;  ns_seq_d   = '0;
    ld_cmt_d   = 1'b0;

    unique case (st_q)
      ST_RUN: begin
        if (sq_req) begin
          st_d       = ST_WALK;
          sqs_d      = sq_seq;
          done_vld_d = 1'b1;
          done_seq_d = sq_seq;
          squash_d   = 1'b1;
          walk_d     = 1'b1;
          mis_d      = sq_mis;
          tkn_d      = sq_tkn;
          npc_d      = sq_npc;
          mpc_d      = sq_mpc;
        end else begin
          if (!rn_stall) begin
            n_ins = tot;
            for (int l = 0; l < RN_W; l++) begin
              if (take[l]) begin
                slot         = wrap_ptr(int'(tail_q) + int'(ofs[l*NW +: NW]));
                seq_we[slot] = 1'b1;
                seq_wd[slot] = rn_seq[l*SEQ_W +: SEQ_W];
                flg_d[slot]  = '{rdy: rn_rdy[l], exe: 1'b0, kil: 1'b0,
                                 nsp: rn_nsp[l], ld: rn_ld[l]};
              end
            end
          end
          tail_d = wrap_ptr(int'(tail_q) + int'(n_ins));
          head_d = wrap_ptr(int'(head_q) + int'(pop));
          cnt_d  = cnt_q + CW'(n_ins) - pop;
          if (sc_ns_vld) flg_d[sc_ns_idx].rdy = 1'b0;
          done_vld_d = sc_done_vld;
          done_seq_d = sc_done_seq;
          ld_cmt_d   = sc_ld;
          ns_vld_d   = sc_ns_vld;
          ns_seq_d   = sc_ns_seq;
        end
      end
      ST_WALK: begin
        if ((cnt_q != '0) && seq_newer(seq_q[tail_m1], sqs_q)) begin
          tail_d     = tail_m1;
          cnt_d      = cnt_q - CW'(1);
          done_vld_d = 1'b1;
          done_seq_d = seq_q[tail_m1];
          walk_d     = 1'b1;
        end else begin
          st_d = ST_RUN;
        end
      end
      default: st_d = ST_RUN;
    endcase

    // completion marks land after this cycle's retire / walk work
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i]) begin
        flg_d[i].rdy = 1'b1;
        flg_d[i].exe = flg_d[i].exe | set_exe[i];
        flg_d[i].kil = flg_d[i].kil | set_kil[i];
      end
    end
  end

  // control and feedback registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      sqs_q       <= '0;
      fb_done_vld <= 1'b0;
      fb_done_seq <= '0;
      fb_squash   <= 1'b0;
      fb_walk     <= 1'b0;
      fb_mis      <= 1'b0;
      fb_tkn      <= 1'b0;
      fb_npc      <= '0;
      fb_mpc      <= '0;
      fb_ns_vld   <= 1'b0;
      fb_ns_seq   <= '0;
      fb_ld_cmt   <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) flg_q[i] <= '0;
    end else begin
      st_q        <= st_d;
      head_q      <= head_d;
      tail_q      <= tail_d;
      cnt_q       <= cnt_d;
      sqs_q       <= sqs_d;
      fb_done_vld <= done_vld_d;
      fb_done_seq <= done_seq_d;
      fb_squash   <= squash_d;
      fb_walk     <= walk_d;
      fb_mis      <= mis_d;
      fb_tkn      <= tkn_d;
      fb_npc      <= npc_d;
      fb_mpc      <= mpc_d;
      fb_ns_vld   <= ns_vld_d;
      fb_ns_seq   <= ns_seq_d;
      fb_ld_cmt   <= ld_cmt_d;
      for (int i = 0; i < ENTRIES; i++) flg_q[i] <= flg_d[i];
    end
  end

  // sequence storage: datapath, write-enabled, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      if (seq_we[i]) seq_q[i] <= seq_wd[i];
  end

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
  parameter int ENTRIES = 8,
  parameter int RN_W    = 2,
  parameter int SEQ_W   = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         st_walk,
  input logic                         sq_req,
  input logic [SEQ_W-1:0]             sq_seq,
  input logic [RN_W-1:0]              rn_vld,
  input logic [RN_W-1:0]              rn_kil,
  input logic                         rn_stall,
  input logic [$clog2(ENTRIES+1)-1:0] fb_free,
  input logic                         fb_done_vld,
  input logic [SEQ_W-1:0]             fb_done_seq,
  input logic                         fb_squash,
  input logic                         fb_walk,
  input logic                         fb_ld_cmt
);
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fb_free) <= ENTRIES); // R12

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rn_stall |-> ($countones(rn_vld & ~rn_kil) <= int'(fb_free))); // R3

  AST_SQ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_walk && sq_req) |=> (fb_squash && fb_walk && fb_done_vld && fb_done_seq == $past(sq_seq))); // R9

  AST_SQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_walk && sq_req) |=> !fb_squash); // R11

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_walk && !fb_squash) |-> (int'(fb_free) == int'($past(fb_free)) + 1)); // R10

  AST_WALK_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    st_walk |=> (int'(fb_free) >= int'($past(fb_free)))); // R10

  AST_LD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_ld_cmt |-> fb_done_vld); // R5
endmodule

bind rob_commit_ctrl rob_commit_chk #(
  .ENTRIES(ENTRIES), .RN_W(RN_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_walk(st_q == rob_pkg::ST_WALK),
  .sq_req(sq_req), .sq_seq(sq_seq), .rn_vld(rn_vld), .rn_kil(rn_kil),
  .rn_stall(rn_stall), .fb_free(fb_free), .fb_done_vld(fb_done_vld),
  .fb_done_seq(fb_done_seq), .fb_squash(fb_squash), .fb_walk(fb_walk),
  .fb_ld_cmt(fb_ld_cmt)
);

// File: tb/rob_commit_ctrl_test.sv
module rob_commit_ctrl_test;
  localparam int N   = 8;
  localparam int RW  = 2;
  localparam int XW  = 2;
  localparam int CMW = 2;
  localparam int SW  = 8;
  localparam int PCW = 32;
  localparam int FW  = $clog2(N+1);

  logic            clk, rst_n;
  logic [RW-1:0]   rn_vld, rn_kil, rn_rdy, rn_nsp, rn_ld;
  logic [RW*SW-1:0] rn_seq;
  logic            rn_stall;
  logic [XW-1:0]   ex_vld, ex_exe, ex_kil;
  logic [XW*SW-1:0] ex_seq;
  logic            sq_req, sq_mis, sq_tkn;
  logic [SW-1:0]   sq_seq;
  logic [PCW-1:0]  sq_npc, sq_mpc;
  logic            fb_done_vld, fb_squash, fb_walk, fb_mis, fb_tkn, fb_ns_vld, fb_ld_cmt;
  logic [SW-1:0]   fb_done_seq, fb_ns_seq;
  logic [PCW-1:0]  fb_npc, fb_mpc;
  logic [FW-1:0]   fb_free;

  int total = 0;
  int bad   = 0;

  rob_commit_ctrl #(.ENTRIES(N), .RN_W(RW), .EX_W(XW), .CM_W(CMW), .SEQ_W(SW), .PC_W(PCW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rn_vld(rn_vld), .rn_seq(rn_seq), .rn_kil(rn_kil), .rn_rdy(rn_rdy),
    .rn_nsp(rn_nsp), .rn_ld(rn_ld), .rn_stall(rn_stall),
    .ex_vld(ex_vld), .ex_seq(ex_seq), .ex_exe(ex_exe), .ex_kil(ex_kil),
    .sq_req(sq_req), .sq_seq(sq_seq), .sq_mis(sq_mis), .sq_tkn(sq_tkn),
    .sq_npc(sq_npc), .sq_mpc(sq_mpc),
    .fb_done_vld(fb_done_vld), .fb_done_seq(fb_done_seq), .fb_squash(fb_squash),
    .fb_walk(fb_walk), .fb_mis(fb_mis), .fb_tkn(fb_tkn), .fb_npc(fb_npc),
    .fb_mpc(fb_mpc), .fb_ns_vld(fb_ns_vld), .fb_ns_seq(fb_ns_seq),
    .fb_ld_cmt(fb_ld_cmt), .fb_free(fb_free)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    rn_vld = '0; rn_seq = '0; rn_kil = '0; rn_rdy = '0; rn_nsp = '0; rn_ld = '0;
    ex_vld = '0; ex_seq = '0; ex_exe = '0; ex_kil = '0;
    sq_req = 1'b0; sq_seq = '0; sq_mis = 1'b0; sq_tkn = 1'b0; sq_npc = '0; sq_mpc = '0;
  endtask

  task automatic set_rn(input int l, input int s, input bit k, input bit r, input bit n, input bit ld);
    rn_vld[l] = 1'b1; rn_seq[l*SW +: SW] = SW'(s);
    rn_kil[l] = k; rn_rdy[l] = r; rn_nsp[l] = n; rn_ld[l] = ld;
  endtask

  task automatic set_ex(input int l, input int s, input bit e, input bit k);
    ex_vld[l] = 1'b1; ex_seq[l*SW +: SW] = SW'(s); ex_exe[l] = e; ex_kil[l] = k;
  endtask

  // advance one edge, then sit 1 ns past it
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ins2(input int a, input int b);
    clr(); set_rn(0, a, 0, 0, 0, 0); set_rn(1, b, 0, 0, 0, 0); tick(); clr();
  endtask

  task automatic t_reset();
    chk("R1", "free", fb_free, N);
    chk("R1", "done_vld", fb_done_vld, 0);
    chk("R1", "walk", fb_walk, 0);
    chk("R1", "ns_vld", fb_ns_vld, 0);
    chk("R1", "stall", rn_stall, 0);
  endtask

  task automatic t_insert();
    ins2(1, 2);
    chk("R2", "free after two", fb_free, 6);
    set_rn(0, 3, 1, 0, 0, 0); set_rn(1, 4, 0, 0, 0, 0); tick(); clr();
    chk("R2", "killed lane dropped", fb_free, 5);
    tick();
    chk("R4", "nothing ready", fb_done_vld, 0);
  endtask

  task automatic t_mark();
    set_ex(0, 1, 1, 0); set_ex(1, 2, 1, 0); tick(); clr();
    chk("R8", "no retire on marking edge", fb_done_vld, 0);
    tick();
    chk("R4", "done_vld", fb_done_vld, 1);
    chk("R4", "done_seq", fb_done_seq, 2);
    chk("R12", "free", fb_free, 7);
    chk("R5", "no load flag", fb_ld_cmt, 0);
    set_ex(0, 4, 1, 0); tick(); clr(); tick();
    chk("R4", "done_seq 4", fb_done_seq, 4);
    chk("R12", "free empty", fb_free, 8);
  endtask

  task automatic t_width();
    ins2(10, 11); ins2(12, 13);
    chk("R2", "free four", fb_free, 4);
    set_ex(0, 12, 1, 0); set_ex(1, 13, 1, 0); tick(); clr();
    chk("R4", "younger ready waits", fb_done_vld, 0);
    set_ex(0, 10, 1, 0); set_ex(1, 11, 1, 0); tick(); clr();
    chk("R4", "head unready waits", fb_done_vld, 0);
    tick();
    chk("R4", "width limit seq", fb_done_seq, 11);
    chk("R4", "width limit free", fb_free, 6);
    tick();
    chk("R4", "rest seq", fb_done_seq, 13);
    chk("R4", "rest free", fb_free, 8);
  endtask

  task automatic t_load();
    set_rn(0, 20, 0, 0, 0, 1); tick(); clr();
    set_ex(0, 20, 1, 0); tick(); clr(); tick();
    chk("R5", "load flag", fb_ld_cmt, 1);
    chk("R5", "load seq", fb_done_seq, 20);
  endtask

  task automatic t_kill();
    ins2(30, 31);
    set_ex(0, 30, 1, 1); set_ex(1, 31, 1, 0); tick(); clr(); tick();
    chk("R6", "seq after silent", fb_done_seq, 31);
    chk("R6", "free", fb_free, 8);
    set_rn(0, 32, 0, 0, 0, 0); tick(); clr();
    set_ex(0, 32, 1, 1); tick(); clr(); tick();
    chk("R6", "silent no done", fb_done_vld, 0);
    chk("R6", "silent removed", fb_free, 8);
    ins2(33, 34);
    set_ex(0, 33, 0, 1); set_ex(1, 34, 1, 0); tick(); clr(); tick();
    chk("R6", "unexecuted killed blocks", fb_free, 6);
    chk("R6", "blocked no done", fb_done_vld, 0);
    set_ex(0, 33, 1, 0); tick(); clr(); tick();
    chk("R6", "unblocked seq", fb_done_seq, 34);
    chk("R6", "unblocked free", fb_free, 8);
  endtask

  task automatic t_nspec();
    clr(); set_rn(0, 40, 0, 1, 1, 0); set_rn(1, 41, 0, 0, 0, 0); tick(); clr();
    chk("R7", "no request on insert edge", fb_ns_vld, 0);
    tick();
    chk("R7", "request", fb_ns_vld, 1);
    chk("R7", "request seq", fb_ns_seq, 40);
    chk("R7", "no retire", fb_done_vld, 0);
    chk("R7", "held", fb_free, 6);
    tick();
    chk("R7", "not repeated", fb_ns_vld, 0);
    set_ex(0, 40, 1, 0); set_ex(1, 41, 1, 0); tick(); clr(); tick();
    chk("R7", "retired after run", fb_done_seq, 41);
    chk("R7", "free", fb_free, 8);
  endtask

  task automatic t_full();
    ins2(50, 51); ins2(52, 53); ins2(54, 55);
    set_rn(0, 56, 0, 0, 0, 0); tick(); clr();
    chk("R12", "free one", fb_free, 1);
    set_rn(0, 57, 0, 0, 0, 0); set_rn(1, 58, 0, 0, 0, 0); #1;
    chk("R3", "two lanes one slot stall", rn_stall, 1);
    tick(); clr();
    chk("R3", "none taken", fb_free, 1);
    set_rn(0, 57, 0, 0, 0, 0); #1;
    chk("R3", "one lane fits", rn_stall, 0);
    tick(); clr();
    chk("R3", "full", fb_free, 0);
    set_rn(0, 58, 1, 0, 0, 0); #1;
    chk("R3", "killed lane no stall", rn_stall, 0);
    tick(); clr();
    set_rn(0, 58, 0, 0, 0, 0); #1;
    chk("R3", "full stall", rn_stall, 1);
    tick(); clr();
    chk("R3", "still full", fb_free, 0);
  endtask

  task automatic t_squash();
    sq_req = 1'b1; sq_seq = 53; sq_mis = 1'b1; sq_tkn = 1'b1;
    sq_npc = 32'h0000_1000; sq_mpc = 32'h0000_0ff0;
    #1;
    chk("R3", "stall on squash", rn_stall, 1);
    tick(); clr();
    chk("R9", "squash", fb_squash, 1);
    chk("R9", "walk", fb_walk, 1);
    chk("R9", "done seq", fb_done_seq, 53);
    chk("R9", "mis", fb_mis, 1);
    chk("R9", "tkn", fb_tkn, 1);
    chk("R9", "npc", fb_npc, 32'h1000);
    chk("R9", "mpc", fb_mpc, 32'h0ff0);
    chk("R9", "free", fb_free, 0);
    tick();
    chk("R10", "step1 seq", fb_done_seq, 57);
    chk("R10", "step1 walk", fb_walk, 1);
    chk("R10", "step1 squash low", fb_squash, 0);
    chk("R10", "step1 free", fb_free, 1);
    set_rn(0, 90, 0, 0, 0, 0); sq_req = 1'b1; sq_seq = 50; #1;
    chk("R10", "stall during walk", rn_stall, 1);
    tick(); clr();
    chk("R11", "second squash ignored", fb_squash, 0);
    chk("R10", "step2 seq", fb_done_seq, 56);
    chk("R10", "step2 free", fb_free, 2);
    tick();
    chk("R10", "step3 seq", fb_done_seq, 55);
    tick();
    chk("R10", "step4 seq", fb_done_seq, 54);
    chk("R10", "step4 free", fb_free, 4);
    tick();
    chk("R10", "walk ends", fb_walk, 0);
    chk("R10", "stop at squash seq", fb_free, 4);
    chk("R10", "no done on exit", fb_done_vld, 0);
    set_ex(0, 50, 1, 0); set_ex(1, 51, 1, 0); tick(); clr();
    set_ex(0, 52, 1, 0); set_ex(1, 53, 1, 0); tick(); clr();
    chk("R11", "older kept", fb_done_seq, 51);
    tick();
    chk("R10", "squasher kept", fb_done_seq, 53);
    chk("R12", "drained", fb_free, 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset();
    @(posedge clk); #1;
    t_insert();
    t_mark();
    t_width();
    t_load();
    t_kill();
    t_nspec();
    t_full();
    t_squash();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule